// File: doc/BRIEF.md
# SPI Master Register Front-End

This block is the software-facing register bank of an SPI master controller. It sits on a simple APB-style bus (select, enable, write, address, write data, read data) and holds the configuration that the serial engine consumes: two control words, a clock divider value, a slave-select enable vector and a global enable. It also holds two small FIFOs, one for words waiting to be shifted out and one for words already received. The serial shifter is not part of the block. It pops transmit words, pushes received words and reports whether a transfer is in progress through a plain strobe-and-data interface.

Configuration is interlocked against the global enable: the control words and the divider take writes only while the controller is off, and data writes reach the transmit FIFO only while it is on. Turning the controller off empties both FIFOs. Address 0x00 is shared: it reads and writes control word 0 while the controller is off, and it is the data port while the controller is on. A window of word addresses starting at 0x60 also behaves as the data port, so a bus burst can stream through it. Six interrupt sources feed a raw status vector. A mask selects which of them reach the single interrupt output. The four event sources stick until software reads their clear location.

Top module: `spi_regif`

## Requirements
- R1: After reset the enable, control words, divider, slave-select, thresholds and FIFO levels read 0, the mask reads 0x3F, raw status reads 0 and irq_o is low.
- R2: Writable registers read back what was written, where the interlocks allow it (control-1 0x04, enable 0x08 bit 0, slave-select 0x10, divider 0x14, TX threshold 0x18, RX threshold 0x1C, mask 0x2C bits 5:0). Address 0x58 returns the ID parameter and 0x5C returns 0x3230312A.
- R3: While enable is 1, writes to control-0, control-1 (0x04) and the divider (0x14) leave them unchanged. Control-0 is reached at 0x00 only while enable is 0.
- R4: While enable is 1, a write to 0x00 or to any word address 0x60 to 0x9C pushes pwdata_i[15:0] into the TX FIFO, and a read there pops the RX FIFO in arrival order. While enable is 0, data writes are dropped and window reads return 0 with no side effect.
- R5: While enable is 0, both FIFO levels (TX level 0x20, RX level 0x24) are 0. Clearing enable empties both FIFOs.
- R6: A write to slave-select is ignored while busy_i is high.
- R7: A data write to a full TX FIFO is dropped and sets raw bit 1. A shifter push to a full RX FIFO is dropped and sets raw bit 3. Each FIFO holds DEPTH (8) words.
- R8: A data read while enabled with the RX FIFO empty returns 0 and sets raw bit 2.
- R9: Raw bit 0 is high when enabled and the TX level is at or below the TX threshold. Raw bit 4 is high when enabled and the RX level is above the RX threshold. Both are levels, not latched.
- R10: Masked status (0x30) equals raw status (0x34) AND mask. irq_o is the OR of the masked bits. Raw bit 5 is set by a pulse on mm_fault_i.
- R11: Reading 0x38, 0x3C, 0x40 or 0x44 returns raw bit 1, 3, 2 or 5 in bit 0 and clears that bit. Reading 0x48 returns the OR of those four bits and clears all four. A set in the same cycle wins over the clear.
- R12: Status (0x28) is read-only and side-effect free: bit 0 busy_i, bit 1 TX not full, bit 2 TX empty, bit 3 RX not empty, bit 4 RX full.
- R13: tx_avail_o is high when enabled and the TX FIFO is not empty, and tx_data_o then shows the oldest word. tx_pop_i removes it. rx_push_i stores rx_data_i. Both strobes are ignored while enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | Bus select |
| penable_i | input | 1 | Bus access phase |
| pwrite_i | input | 1 | Bus write (1) or read (0) |
| paddr_i | input | AW | Byte address |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, valid while selected for a read |
| busy_i | input | 1 | Shifter transfer in progress |
| tx_pop_i | input | 1 | Shifter takes the oldest TX word |
| tx_data_o | output | DW | Oldest TX word, 0 when empty |
| tx_avail_o | output | 1 | TX word available |
| rx_push_i | input | 1 | Shifter delivers a received word |
| rx_data_i | input | DW | Received word |
| mm_fault_i | input | 1 | Multi-master contention event |
| enable_o | output | 1 | Global enable |
| ctrl0_o | output | DW | Control word 0 |
| ctrl1_o | output | DW | Control word 1 |
| baud_o | output | DW | Clock divider value |
| ss_en_o | output | NSS | Slave-select enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest situations to reach from the ports are the overflow corners. TX overflow needs nine data writes with no shifter pop in between. RX overflow needs nine shifter pushes with no bus read. Either one can also fall together with the controller being switched off, and a flush must then leave the sticky flags intact while both levels fall to zero. Directed sequences fill each FIFO through different window aliases, go past full, drain past empty and toggle the enable with data still queued. A long stretch of seeded random bus reads, writes, enable toggles, busy changes and shifter strobes then checks every read word and configuration output against a queue-based model.

// File: rtl/spi_regif_pkg.sv
`timescale 1ns/1ps
package spi_regif_pkg;
  localparam logic [7:0] A_CTRL0   = 8'h00;
  localparam logic [7:0] A_CTRL1   = 8'h04;
  localparam logic [7:0] A_EN      = 8'h08;
  localparam logic [7:0] A_SS      = 8'h10;
  localparam logic [7:0] A_BAUD    = 8'h14;
  localparam logic [7:0] A_TXTHR   = 8'h18;
  localparam logic [7:0] A_RXTHR   = 8'h1C;
  localparam logic [7:0] A_TXLVL   = 8'h20;
  localparam logic [7:0] A_RXLVL   = 8'h24;
  localparam logic [7:0] A_STAT    = 8'h28;
  localparam logic [7:0] A_MASK    = 8'h2C;
  localparam logic [7:0] A_MSTAT   = 8'h30;
  localparam logic [7:0] A_RAW     = 8'h34;
  localparam logic [7:0] A_CLR_TXO = 8'h38;
  localparam logic [7:0] A_CLR_RXO = 8'h3C;
  localparam logic [7:0] A_CLR_RXU = 8'h40;
  localparam logic [7:0] A_CLR_MST = 8'h44;
  localparam logic [7:0] A_CLR_ALL = 8'h48;
  localparam logic [7:0] A_ID      = 8'h58;
  localparam logic [7:0] A_VER     = 8'h5C;

  localparam int IRQ_N   = 6;
  localparam int IRQ_TXE = 0;
  localparam int IRQ_TXO = 1;
  localparam int IRQ_RXU = 2;
  localparam int IRQ_RXO = 3;
  localparam int IRQ_RXF = 4;
  localparam int IRQ_MST = 5;
  // level-type sources; the rest are sticky events
  localparam logic [IRQ_N-1:0] IRQ_LEVEL = 6'b01_0001;

  localparam logic [31:0] VERSION_WORD = 32'h3230_312A;

  typedef enum logic [4:0] {
    S_NONE, S_DATA, S_CTRL0, S_CTRL1, S_EN, S_SS, S_BAUD, S_TXTHR, S_RXTHR,
    S_TXLVL, S_RXLVL, S_STAT, S_MASK, S_MSTAT, S_RAW, S_CLR_TXO, S_CLR_RXO,
    S_CLR_RXU, S_CLR_MST, S_CLR_ALL, S_ID, S_VER
  } sel_e;
endpackage

// File: rtl/spi_regif_fifo.sv
`timescale 1ns/1ps
module spi_regif_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [LW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == LW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign data_o  = mem[rd_ptr_q];
  assign level_o = cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spi_regif_dec.sv
`timescale 1ns/1ps
module spi_regif_dec
  import spi_regif_pkg::*;
#(
  parameter int             AW         = 8,
  parameter logic [AW-1:0]  DATA_BASE  = AW'(8'h60),
  parameter int             DATA_WORDS = 16,
  localparam int            BASE_W     = int'(DATA_BASE) >> 2
) (
  input  logic [AW-1:0] addr_i,
  input  logic          en_i,
  output sel_e          sel_o
);
  logic in_win;
  assign in_win = (int'(addr_i[AW-1:2]) >= BASE_W) &&
                  (int'(addr_i[AW-1:2]) < BASE_W + DATA_WORDS);

  always_comb begin
    sel_o = S_NONE;
    if (in_win) begin
      sel_o = S_DATA;
    end else begin
      case (addr_i)
        AW'(A_CTRL0):   sel_o = en_i ? S_DATA : S_CTRL0;  // shared slot
        AW'(A_CTRL1):   sel_o = S_CTRL1;
        AW'(A_EN):      sel_o = S_EN;
        AW'(A_SS):      sel_o = S_SS;
        AW'(A_BAUD):    sel_o = S_BAUD;
        AW'(A_TXTHR):   sel_o = S_TXTHR;
        AW'(A_RXTHR):   sel_o = S_RXTHR;
        AW'(A_TXLVL):   sel_o = S_TXLVL;
        AW'(A_RXLVL):   sel_o = S_RXLVL;
        AW'(A_STAT):    sel_o = S_STAT;
        AW'(A_MASK):    sel_o = S_MASK;
        AW'(A_MSTAT):   sel_o = S_MSTAT;
        AW'(A_RAW):     sel_o = S_RAW;
        AW'(A_CLR_TXO): sel_o = S_CLR_TXO;
        AW'(A_CLR_RXO): sel_o = S_CLR_RXO;
        AW'(A_CLR_RXU): sel_o = S_CLR_RXU;
        AW'(A_CLR_MST): sel_o = S_CLR_MST;
        AW'(A_CLR_ALL): sel_o = S_CLR_ALL;
        AW'(A_ID):      sel_o = S_ID;
        AW'(A_VER):     sel_o = S_VER;
        default:        sel_o = S_NONE;
      endcase
    end
  end
endmodule

// File: rtl/spi_regif_irq.sv
`timescale 1ns/1ps
module spi_regif_irq
  import spi_regif_pkg::*;
#(
  parameter int             N     = IRQ_N,
  parameter logic [N-1:0]   LEVEL = IRQ_LEVEL
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,   // level value or set pulse
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] masked_o,
  output logic         irq_o
);
  for (genvar i = 0; i < N; i++) begin : g_src
    if (LEVEL[i]) begin : g_lvl
      logic unused_clr;
      assign unused_clr = clr_i[i];
      assign raw_o[i]   = src_i[i];
    end else begin : g_stk
      logic st_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       st_q <= 1'b0;
        else if (src_i[i]) st_q <= 1'b1;   // set wins
        else if (clr_i[i]) st_q <= 1'b0;
      end
      assign raw_o[i] = st_q;
    end
  end

  assign masked_o = raw_o & mask_i;
  assign irq_o    = |masked_o;
endmodule

// File: rtl/spi_regif.sv
`timescale 1ns/1ps
module spi_regif
  import spi_regif_pkg::*;
#(
  parameter int            AW         = 8,
  parameter int            DW         = 16,
  parameter int            DEPTH      = 8,
  parameter int            NSS        = 4,
  parameter logic [AW-1:0] DATA_BASE  = AW'(8'h60),
  parameter int            DATA_WORDS = 16,
  parameter logic [31:0]   ID_CODE    = 32'h0000_51C0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           psel_i,
  input  logic           penable_i,
  input  logic           pwrite_i,
  input  logic [AW-1:0]  paddr_i,
  input  logic [31:0]    pwdata_i,
  output logic [31:0]    prdata_o,
  input  logic           busy_i,
  input  logic           tx_pop_i,
  output logic [DW-1:0]  tx_data_o,
  output logic           tx_avail_o,
  input  logic           rx_push_i,
  input  logic [DW-1:0]  rx_data_i,
  input  logic           mm_fault_i,
  output logic           enable_o,
  output logic [DW-1:0]  ctrl0_o,
  output logic [DW-1:0]  ctrl1_o,
  output logic [DW-1:0]  baud_o,
  output logic [NSS-1:0] ss_en_o,
  output logic           irq_o
);
  localparam int LW = $clog2(DEPTH + 1);

  logic           en_q;
  logic [DW-1:0]  ctrl0_q, ctrl1_q, baud_q;
  logic [NSS-1:0] ss_q;
  logic [LW-1:0]  tx_thr_q, rx_thr_q;
  logic [IRQ_N-1:0] mask_q;

  sel_e sel;
  logic wr, rd, flush;
  logic tx_push, tx_pop, rx_push, rx_pop, rx_rd;
  logic [DW-1:0] tx_head, rx_head;
  logic [LW-1:0] tx_lvl, rx_lvl;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [IRQ_N-1:0] irq_src, irq_clr, irq_raw, irq_masked;
  logic [31:0] rdata;

  logic unused_wdata;
  assign unused_wdata = ^pwdata_i[31:DW];

  spi_regif_dec #(.AW(AW), .DATA_BASE(DATA_BASE), .DATA_WORDS(DATA_WORDS)) u_dec (
    .addr_i(paddr_i), .en_i(en_q), .sel_o(sel)
  );

  assign wr    = psel_i && penable_i && pwrite_i;
  assign rd    = psel_i && penable_i && !pwrite_i;
  assign flush = !en_q;

  assign tx_push = wr && (sel == S_DATA) && en_q;
  assign rx_rd   = rd && (sel == S_DATA) && en_q;
  assign rx_pop  = rx_rd;
  assign tx_pop  = tx_pop_i && en_q;
  assign rx_push = rx_push_i && en_q;

  spi_regif_fifo #(.W(DW), .DEPTH(DEPTH)) u_txf (
    .clk_i, .rst_ni, .flush_i(flush),
    .push_i(tx_push), .data_i(pwdata_i[DW-1:0]),
    .pop_i(tx_pop), .data_o(tx_head),
    .level_o(tx_lvl), .full_o(tx_full), .empty_o(tx_empty)
  );

  spi_regif_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxf (
    .clk_i, .rst_ni, .flush_i(flush),
    .push_i(rx_push), .data_i(rx_data_i),
    .pop_i(rx_pop), .data_o(rx_head),
    .level_o(rx_lvl), .full_o(rx_full), .empty_o(rx_empty)
  );

  // configuration registers with interlocks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      ctrl0_q  <= '0;
      ctrl1_q  <= '0;
      baud_q   <= '0;
      ss_q     <= '0;
      tx_thr_q <= '0;
      rx_thr_q <= '0;
      mask_q   <= '1;
    end else if (wr) begin
      case (sel)
        S_CTRL0: if (!en_q)   ctrl0_q  <= pwdata_i[DW-1:0];
        S_CTRL1: if (!en_q)   ctrl1_q  <= pwdata_i[DW-1:0];
        S_BAUD:  if (!en_q)   baud_q   <= pwdata_i[DW-1:0];
        S_SS:    if (!busy_i) ss_q     <= pwdata_i[NSS-1:0];
        S_EN:                 en_q     <= pwdata_i[0];
        S_TXTHR:              tx_thr_q <= pwdata_i[LW-1:0];
        S_RXTHR:              rx_thr_q <= pwdata_i[LW-1:0];
        S_MASK:               mask_q   <= pwdata_i[IRQ_N-1:0];
        default: ;
      endcase
    end
  end

  // interrupt sources
  always_comb begin
    irq_src          = '0;
    irq_src[IRQ_TXE] = en_q && (tx_lvl <= tx_thr_q);
    irq_src[IRQ_TXO] = tx_push && tx_full;
    irq_src[IRQ_RXU] = rx_rd && rx_empty;
    irq_src[IRQ_RXO] = rx_push && rx_full;
    irq_src[IRQ_RXF] = en_q && (rx_lvl > rx_thr_q);
    irq_src[IRQ_MST] = mm_fault_i;

    irq_clr          = '0;
    irq_clr[IRQ_TXO] = rd && (sel == S_CLR_TXO || sel == S_CLR_ALL);
    irq_clr[IRQ_RXO] = rd && (sel == S_CLR_RXO || sel == S_CLR_ALL);
    irq_clr[IRQ_RXU] = rd && (sel == S_CLR_RXU || sel == S_CLR_ALL);
    irq_clr[IRQ_MST] = rd && (sel == S_CLR_MST || sel == S_CLR_ALL);
  end

  spi_regif_irq u_irq (
    .clk_i, .rst_ni,
    .src_i(irq_src), .clr_i(irq_clr), .mask_i(mask_q),
    .raw_o(irq_raw), .masked_o(irq_masked), .irq_o(irq_o)
  );

  // read mux
  always_comb begin
    rdata = '0;
    case (sel)
      S_DATA:    if (en_q && !rx_empty) rdata[DW-1:0] = rx_head;
      S_CTRL0:   rdata[DW-1:0]    = ctrl0_q;
      S_CTRL1:   rdata[DW-1:0]    = ctrl1_q;
      S_EN:      rdata[0]         = en_q;
      S_SS:      rdata[NSS-1:0]   = ss_q;
      S_BAUD:    rdata[DW-1:0]    = baud_q;
      S_TXTHR:   rdata[LW-1:0]    = tx_thr_q;
      S_RXTHR:   rdata[LW-1:0]    = rx_thr_q;
      S_TXLVL:   rdata[LW-1:0]    = tx_lvl;
      S_RXLVL:   rdata[LW-1:0]    = rx_lvl;
      S_STAT:    rdata[4:0]       = {rx_full, !rx_empty, tx_empty, !tx_full, busy_i};
      S_MASK:    rdata[IRQ_N-1:0] = mask_q;
      S_MSTAT:   rdata[IRQ_N-1:0] = irq_masked;
      S_RAW:     rdata[IRQ_N-1:0] = irq_raw;
      S_CLR_TXO: rdata[0]         = irq_raw[IRQ_TXO];
      S_CLR_RXO: rdata[0]         = irq_raw[IRQ_RXO];
      S_CLR_RXU: rdata[0]         = irq_raw[IRQ_RXU];
      S_CLR_MST: rdata[0]         = irq_raw[IRQ_MST];
      S_CLR_ALL: rdata[0]         = |(irq_raw & ~IRQ_LEVEL);
      S_ID:      rdata            = ID_CODE;
      S_VER:     rdata            = VERSION_WORD;
      default:   rdata            = '0;
    endcase
  end

  assign prdata_o   = (psel_i && !pwrite_i) ? rdata : '0;
  assign tx_avail_o = en_q && !tx_empty;
  assign tx_data_o  = tx_avail_o ? tx_head : '0;
  assign enable_o   = en_q;
  assign ctrl0_o    = ctrl0_q;
  assign ctrl1_o    = ctrl1_q;
  assign baud_o     = baud_q;
  assign ss_en_o    = ss_q;
endmodule

// File: rtl/spi_regif_chk.sv
`timescale 1ns/1ps
module spi_regif_chk
  import spi_regif_pkg::*;
#(
  parameter int  DW    = 16,
  parameter int  DEPTH = 8,
  parameter int  NSS   = 4,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_o,
  input logic [DW-1:0]    ctrl0_o,
  input logic [DW-1:0]    ctrl1_o,
  input logic [DW-1:0]    baud_o,
  input logic [NSS-1:0]   ss_en_o,
  input logic             busy_i,
  input logic             tx_avail_o,
  input logic             irq_o,
  input logic [LW-1:0]    tx_lvl,
  input logic [LW-1:0]    rx_lvl,
  input logic             tx_push,
  input logic             tx_full,
  input logic [IRQ_N-1:0] raw,
  input logic [IRQ_N-1:0] mask
);
  a_r3_cfg_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_o |=> ($stable(ctrl0_o) && $stable(ctrl1_o) && $stable(baud_o)));

  a_r5_flush_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_o |=> (tx_lvl == '0 && rx_lvl == '0));

  a_r6_ss_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(ss_en_o));

  a_r7_txovf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_push && tx_full) |=> raw[IRQ_TXO]);

  a_r7_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_lvl <= LW'(DEPTH)) && (rx_lvl <= LW'(DEPTH)));

  a_r10_mask_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> !irq_o);

  a_r13_no_avail_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_o |-> !tx_avail_o);
endmodule

bind spi_regif spi_regif_chk #(.DW(DW), .DEPTH(DEPTH), .NSS(NSS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_o(enable_o), .ctrl0_o(ctrl0_o),
  .ctrl1_o(ctrl1_o), .baud_o(baud_o), .ss_en_o(ss_en_o), .busy_i(busy_i),
  .tx_avail_o(tx_avail_o), .irq_o(irq_o), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
  .tx_push(tx_push), .tx_full(tx_full), .raw(irq_raw), .mask(mask_q)
);

// File: tb/spi_regif_tb.sv
`timescale 1ns/1ps
module spi_regif_tb;
  localparam int DEPTH = 8;
  localparam logic [31:0] ID_EXP = 32'h0000_51C0;

  logic clk = 0, rst_ni = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic busy = 0, tx_pop = 0, rx_push = 0, mm_fault = 0;
  logic [15:0] rx_data = 0, tx_data, ctrl0, ctrl1, baud;
  logic tx_avail, enable, irq;
  logic [3:0] ss_en;

  spi_regif u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .busy_i(busy), .tx_pop_i(tx_pop), .tx_data_o(tx_data), .tx_avail_o(tx_avail),
    .rx_push_i(rx_push), .rx_data_i(rx_data), .mm_fault_i(mm_fault),
    .enable_o(enable), .ctrl0_o(ctrl0), .ctrl1_o(ctrl1), .baud_o(baud),
    .ss_en_o(ss_en), .irq_o(irq)
  );

  always #10 clk = ~clk;  // 50 MHz

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model
  bit m_en, m_busy, s_txo, s_rxu, s_rxo, s_mst;
  logic [15:0] m_c0, m_c1, m_bd;
  logic [3:0] m_ss;
  int m_txt, m_rxt;
  logic [5:0] m_mask = 6'h3F;
  logic [15:0] q_tx[$], q_rx[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] m_raw();
    logic [5:0] r;
    r[0] = m_en && (q_tx.size() <= m_txt);
    r[1] = s_txo;
    r[2] = s_rxu;
    r[3] = s_rxo;
    r[4] = m_en && (q_rx.size() > m_rxt);
    r[5] = s_mst;
    return r;
  endfunction

  function automatic bit in_win(logic [7:0] a);
    return a >= 8'h60 && a <= 8'h9F;
  endfunction

  function automatic string tag_of(logic [7:0] a);
    if (a == 8'h00 || in_win(a)) return "R4";
    if (a == 8'h20 || a == 8'h24) return "R5";
    if (a == 8'h28) return "R12";
    if (a == 8'h30 || a == 8'h34) return "R10";
    if (a >= 8'h38 && a <= 8'h48) return "R11";
    return "R2";
  endfunction

  task automatic m_wr(logic [7:0] a, logic [31:0] d);
    if (a == 8'h00 || in_win(a)) begin
      if (m_en) begin
        if (q_tx.size() < DEPTH) q_tx.push_back(d[15:0]); else s_txo = 1;
      end else if (a == 8'h00) m_c0 = d[15:0];
    end else case (a)
      8'h04: if (!m_en) m_c1 = d[15:0];
      8'h08: begin m_en = d[0]; if (!m_en) begin q_tx.delete(); q_rx.delete(); end end
      8'h10: if (!m_busy) m_ss = d[3:0];
      8'h14: if (!m_en) m_bd = d[15:0];
      8'h18: m_txt = int'(d[3:0]);
      8'h1C: m_rxt = int'(d[3:0]);
      8'h2C: m_mask = d[5:0];
      default: ;
    endcase
  endtask

  task automatic m_rd(logic [7:0] a, output logic [31:0] e);
    logic [5:0] r;
    r = m_raw();
    e = '0;
    if (a == 8'h00 && !m_en) e = {16'h0, m_c0};
    else if (a == 8'h00 || in_win(a)) begin
      if (m_en) begin
        if (q_rx.size() == 0) s_rxu = 1;
        else e = {16'h0, q_rx.pop_front()};
      end
    end else case (a)
      8'h04: e = {16'h0, m_c1};
      8'h08: e = {31'h0, m_en};
      8'h10: e = {28'h0, m_ss};
      8'h14: e = {16'h0, m_bd};
      8'h18: e = m_txt;
      8'h1C: e = m_rxt;
      8'h20: e = q_tx.size();
      8'h24: e = q_rx.size();
      8'h28: e = {27'h0, q_rx.size() == DEPTH, q_rx.size() != 0, q_tx.size() == 0,
                  q_tx.size() != DEPTH, m_busy};
      8'h2C: e = {26'h0, m_mask};
      8'h30: e = {26'h0, r & m_mask};
      8'h34: e = {26'h0, r};
      8'h38: begin e = s_txo; s_txo = 0; end
      8'h3C: begin e = s_rxo; s_rxo = 0; end
      8'h40: begin e = s_rxu; s_rxu = 0; end
      8'h44: begin e = s_mst; s_mst = 0; end
      8'h48: begin e = s_txo | s_rxo | s_rxu | s_mst; s_txo = 0; s_rxo = 0; s_rxu = 0; s_mst = 0; end
      8'h58: e = ID_EXP;
      8'h5C: e = 32'h3230_312A;
      default: ;
    endcase
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    m_wr(a, d);
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; #2 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic rd_chk(logic [7:0] a, string req = "");
    logic [31:0] e, d;
    m_rd(a, e);
    bus_rd(a, d);
    check(req == "" ? tag_of(a) : req, d, e);
  endtask

  task automatic shf_pop();
    @(negedge clk);
    check("R13", {31'h0, tx_avail}, {31'h0, m_en && q_tx.size() > 0});
    if (m_en && q_tx.size() > 0) check("R13", {16'h0, tx_data}, {16'h0, q_tx[0]});
    tx_pop = 1;
    @(negedge clk); tx_pop = 0;
    if (m_en && q_tx.size() > 0) void'(q_tx.pop_front());
  endtask

  task automatic shf_push(logic [15:0] d);
    @(negedge clk); rx_push = 1; rx_data = d;
    @(negedge clk); rx_push = 0;
    if (m_en) begin
      if (q_rx.size() < DEPTH) q_rx.push_back(d); else s_rxo = 1;
    end
  endtask

  task automatic mm_pulse();
    @(negedge clk); mm_fault = 1;
    @(negedge clk); mm_fault = 0;
    s_mst = 1;
  endtask

  task automatic set_busy(bit b);
    @(negedge clk); busy = b; m_busy = b;
  endtask

  task automatic chk_outs();
    @(negedge clk);
    check("R3", {enable, ctrl0, ctrl1}, {m_en, m_c0, m_c1});
    check("R3", {16'h0, baud}, {16'h0, m_bd});
    check("R6", {28'h0, ss_en}, {28'h0, m_ss});
    check("R10", {31'h0, irq}, {31'h0, |(m_raw() & m_mask)});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    chk_outs();
    check("R1", {31'h0, irq}, 32'h0);
    rd_chk(8'h00, "R1"); rd_chk(8'h2C, "R1"); rd_chk(8'h34, "R1");
    rd_chk(8'h20, "R1"); rd_chk(8'h24, "R1");
    // R2 readback and constants
    bus_wr(8'h00, 32'h1234); bus_wr(8'h04, 32'hBEEF); bus_wr(8'h14, 32'h0042);
    bus_wr(8'h10, 32'h5);    bus_wr(8'h18, 32'h3);    bus_wr(8'h1C, 32'h1);
    rd_chk(8'h00, "R2"); rd_chk(8'h04, "R2"); rd_chk(8'h14, "R2");
    rd_chk(8'h10, "R2"); rd_chk(8'h58, "R2"); rd_chk(8'h5C, "R2");
    // R3 interlock while enabled
    bus_wr(8'h08, 1);
    bus_wr(8'h04, 32'h1111); bus_wr(8'h14, 32'h2222);
    rd_chk(8'h04, "R3"); rd_chk(8'h14, "R3");
    chk_outs();
    // R4 / R7 fill TX through 0x00 and aliases, overflow on ninth
    bus_wr(8'h00, 32'hA000);
    for (int i = 1; i < 9; i++) bus_wr(8'h60 + 8'(4 * i), 32'hA000 + i);
    rd_chk(8'h20, "R7"); rd_chk(8'h34, "R7"); rd_chk(8'h28, "R12");
    rd_chk(8'h38, "R11"); rd_chk(8'h38, "R11");
    // R13 shifter drains in order
    for (int i = 0; i < 5; i++) shf_pop();
    rd_chk(8'h34, "R9");
    // R7 RX overflow, R4 ordered pops, R8 underflow
    for (int i = 0; i < 9; i++) shf_push(16'hC000 + 16'(i));
    rd_chk(8'h24, "R7"); rd_chk(8'h3C, "R11");
    for (int i = 0; i < 9; i++) rd_chk(8'h7C, i < 8 ? "R4" : "R8");
    rd_chk(8'h34, "R8"); rd_chk(8'h40, "R11");
    // R9 thresholds
    bus_wr(8'h18, 0); rd_chk(8'h34, "R9");
    bus_wr(8'h1C, 0); shf_push(16'h55AA); rd_chk(8'h34, "R9");
    // R6 busy blocks slave-select
    set_busy(1); bus_wr(8'h10, 32'hA); rd_chk(8'h10, "R6");
    set_busy(0); bus_wr(8'h10, 32'hA); rd_chk(8'h10, "R6");
    // R10 mask gate, multi-master
    mm_pulse(); bus_wr(8'h2C, 0); chk_outs(); rd_chk(8'h30, "R10");
    bus_wr(8'h2C, 32'h20); chk_outs(); rd_chk(8'h48, "R11"); chk_outs();
    bus_wr(8'h2C, 32'h3F);
    // R5 disable flushes, R13 strobes ignored, window read silent
    bus_wr(8'h64, 32'h7777);
    bus_wr(8'h08, 0);
    rd_chk(8'h20, "R5"); rd_chk(8'h24, "R5");
    shf_push(16'h9999); shf_pop(); bus_wr(8'h70, 32'h1);
    rd_chk(8'h70, "R4"); rd_chk(8'h34, "R13");
    bus_wr(8'h08, 1); rd_chk(8'h24, "R13"); rd_chk(8'h20, "R4");

    // seeded random mix
    for (int n = 0; n < 3000; n++) begin
      int op;
      logic [7:0] a;
      logic [7:0] regs[20] = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20,
                               8'h24, 8'h28, 8'h2C, 8'h30, 8'h34, 8'h38, 8'h3C, 8'h40,
                               8'h44, 8'h48, 8'h58, 8'h5C};
      op = int'($urandom_range(0, 99));
      a = ($urandom_range(0, 2) == 0) ? 8'h60 + 8'(4 * $urandom_range(0, 15))
                                      : regs[$urandom_range(0, 19)];
      if (op < 30) begin
        if (a != 8'h08) bus_wr(a, $urandom());
      end else if (op < 60) rd_chk(a);
      else if (op < 72) shf_pop();
      else if (op < 84) shf_push(16'($urandom()));
      else if (op < 90) set_busy(1'($urandom_range(0, 1)));
      else if (op < 94) bus_wr(8'h08, 32'($urandom_range(0, 1)));
      else if (op < 96) mm_pulse();
      else bus_wr(8'h00, $urandom());
      if (n % 10 == 0) chk_outs();
    end
    chk_outs();
    bus_rd(8'h5C, d);
    check("R2", d, 32'h3230_312A);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule